// File: doc/BRIEF.md
# Destination Port Message Checker

This block is the network-side receive interface of one destination processor in a circuit-switched multistage network that routes by tags carried in the message itself. Words arrive on a 16-bit data bus with two parity bits and are qualified by an active-low data-available line. The port reacts only to a high-to-low transition of that line. The first word after a request is the setup word. Its low four bits must name this port, and every word must have correct even parity in each byte.

The block has no error flag. It reports a bad word by withholding its active-low grant and data-received returns, so the source sees a missing acknowledgement. Each accepted data word goes to the local processor as a one-cycle valid pulse with the word beside it. When the request line is negated, the port goes back to waiting for a new setup word.

The controller has four states. IDLE means no request. SETUP means a request is present and the setup word is awaited. OPEN means the path is granted. BLOCKED means an error was seen. The transitions are:
- IDLE to SETUP on request asserted.
- SETUP to OPEN on a setup word with good parity and a matching address.
- SETUP to BLOCKED on a setup word that fails either check.
- OPEN to BLOCKED on a data word with bad parity.
- Any state to IDLE on request negated.

Top module: `dst_port_checker`

## Requirements
- R1: Parity is even per byte. `par_i[1]` must equal the XOR of `data_i[15:8]` and `par_i[0]` the XOR of `data_i[7:0]`. A word that fails either byte is rejected, whether it is a setup word or a data word.
- R2: A setup word whose bits 3..0 differ from the port's own address is rejected. The port then asserts neither grant nor data-received until the request is negated.
- R3: A word is taken only when `dav_n_i` was sampled high on one clock and low on the next, with `req_n_i` low. Holding `dav_n_i` low delivers no further word.
- R4: All protocol lines are active low. Reset leaves `grant_n_o`=1, `drcv_n_o`=1 and `out_valid_o`=0.
- R5: On an accepted setup word, `grant_n_o` and `drcv_n_o` go low one clock after the sampled edge. Grant stays low until the request is negated or an error occurs.
- R6: On an accepted data word in the OPEN state, `out_valid_o` is high for exactly one cycle, one clock after the edge, with `out_data_o` equal to the word. In the same cycle `drcv_n_o` goes low.
- R7: While OPEN, `drcv_n_o` returns high one clock after `dav_n_i` is sampled high, so every accepted word yields a fresh falling edge.
- R8: A data word with bad parity drives `grant_n_o` and `drcv_n_o` high on the next clock, with no valid pulse. All later words are ignored until the request is negated.
- R9: While `req_n_i` is sampled high, all outputs return to idle on the next clock. The first clock with the request asserted only arms the port, so an edge in that cycle is not taken.
- R10: The own address is captured from `own_addr_i` while `rst_n` is low. Changing `own_addr_i` after reset has no effect.
- R11: The setup word is never presented on `out_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; own address is captured while low |
| own_addr_i | input | 4 | Address of this destination port |
| req_n_i | input | 1 | Message request, active low |
| dav_n_i | input | 1 | Data available, active low, edge sensitive |
| data_i | input | 16 | Data word from the network |
| par_i | input | 2 | Even parity: bit 1 for bits 15..8, bit 0 for bits 7..0 |
| grant_n_o | output | 1 | Message grant toward the source, active low |
| drcv_n_o | output | 1 | Data received toward the source, active low |
| out_valid_o | output | 1 | One-cycle pulse for an accepted data word |
| out_data_o | output | 16 | Accepted data word |

## Verification
Every port result is registered once behind the clock edge that samples the falling `dav_n_i`. Grant, data-received and the valid pulse therefore appear one clock after the edge is seen, and idle outputs follow one clock after the request is sampled high. The bench drives inputs on the falling clock edge. A behavioural model advances on the rising edge, and the outputs are compared against it on each falling edge, exactly one cycle after the stimulus that caused them. Point checks at the end of each scenario count valid pulses and read the handshake lines, covering the held-low data line, errors and address capture.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_OPEN,
        ST_BLOCKED
    } port_state_e;
endpackage

// File: rtl/dpc_fall_detect.sv
module dpc_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n_i,
    output logic fall_o
);
    logic line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_n_i;
    end

    // high on the previous clock, low now
    assign fall_o = line_q & ~line_n_i;
endmodule

// File: rtl/dpc_word_check.sv
module dpc_word_check #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4,
    parameter int NBYTES = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [NBYTES-1:0] par_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              par_ok_o,
    output logic              addr_ok_o
);
    logic [NBYTES-1:0] byte_ok;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_ok[b] = ((^word_i[b*BYTE_W +: BYTE_W]) == par_i[b]);
    end

    assign par_ok_o  = &byte_ok;
    assign addr_ok_o = (word_i[ADDR_W-1:0] == addr_i);
endmodule

// File: rtl/dst_port_checker.sv
module dst_port_checker #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          own_addr_i,
    input  logic                       req_n_i,
    input  logic                       dav_n_i,
    input  logic [DATA_W-1:0]          data_i,
    input  logic [DATA_W/BYTE_W-1:0]   par_i,
    output logic                       grant_n_o,
    output logic                       drcv_n_o,
    output logic                       out_valid_o,
    output logic [DATA_W-1:0]          out_data_o
);
    import dpc_pkg::*;

    localparam int NBYTES = DATA_W / BYTE_W;

    port_state_e       state_q, state_d;
    logic [ADDR_W-1:0] my_addr_q;
    logic              dav_fall;
    logic              par_ok;
    logic              addr_ok;
    logic              grant_d, drcv_d, valid_d;
    logic [DATA_W-1:0] data_d;

    // address follows the input only while reset is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) my_addr_q <= own_addr_i;
        else        my_addr_q <= my_addr_q;
    end

    dpc_fall_detect u_dav_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n_i (dav_n_i),
        .fall_o   (dav_fall)
    );

    dpc_word_check #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES)
    ) u_check (
        .word_i    (data_i),
        .par_i     (par_i),
        .addr_i    (my_addr_q),
        .par_ok_o  (par_ok),
        .addr_ok_o (addr_ok)
    );

    // next state and next outputs
    always_comb begin
        state_d = state_q;
        grant_d = grant_n_o;
        drcv_d  = drcv_n_o;
        valid_d = 1'b0;
        data_d  = out_data_o;
        if (req_n_i) begin
            state_d = ST_IDLE;
            grant_d = 1'b1;
            drcv_d  = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_SETUP;
                end
                ST_SETUP: begin
                    if (dav_fall) begin
                        if (par_ok && addr_ok) begin
                            state_d = ST_OPEN;
                            grant_d = 1'b0;
                            drcv_d  = 1'b0;
                        end else begin
                            state_d = ST_BLOCKED;
                            grant_d = 1'b1;
                            drcv_d  = 1'b1;
                        end
                    end
                end
                ST_OPEN: begin
                    if (dav_fall) begin
                        if (par_ok) begin
                            drcv_d  = 1'b0;
                            valid_d = 1'b1;
                            data_d  = data_i;
                        end else begin
                            state_d = ST_BLOCKED;
                            grant_d = 1'b1;
                            drcv_d  = 1'b1;
                        end
                    end else if (dav_n_i) begin
                        drcv_d = 1'b1;
                    end
                end
                ST_BLOCKED: begin
                    grant_d = 1'b1;
                    drcv_d  = 1'b1;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_n_o   <= 1'b1;
            drcv_n_o    <= 1'b1;
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else begin
            grant_n_o   <= grant_d;
            drcv_n_o    <= drcv_d;
            out_valid_o <= valid_d;
            out_data_o  <= data_d;
        end
    end
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_n_i,
    input logic                     dav_n_i,
    input logic [DATA_W-1:0]        data_i,
    input logic [DATA_W/BYTE_W-1:0] par_i,
    input logic                     grant_n_o,
    input logic                     drcv_n_o,
    input logic                     out_valid_o
);
    localparam int NB = DATA_W / BYTE_W;

    logic          dav_q1, dav_q2;
    logic          par_good_q;
    logic [NB-1:0] par_calc;

    always_comb begin
        for (int b = 0; b < NB; b++) par_calc[b] = ^data_i[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dav_q1     <= 1'b1;
            dav_q2     <= 1'b1;
            par_good_q <= 1'b0;
        end else begin
            dav_q1     <= dav_n_i;
            dav_q2     <= dav_q1;
            par_good_q <= (par_calc == par_i);
        end
    end

    AST_REQ_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_n_i |=> (grant_n_o && drcv_n_o && !out_valid_o)); // R9

    AST_VALID_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !grant_n_o); // R6

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> !out_valid_o); // R3

    AST_ACK_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drcv_n_o) |-> (!dav_q1 && dav_q2)); // R3

    AST_ACK_GOOD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drcv_n_o) |-> par_good_q); // R1
endmodule

bind dst_port_checker dpc_checker #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
) u_dpc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n_i     (req_n_i),
    .dav_n_i     (dav_n_i),
    .data_i      (data_i),
    .par_i       (par_i),
    .grant_n_o   (grant_n_o),
    .drcv_n_o    (drcv_n_o),
    .out_valid_o (out_valid_o)
);

// File: tb/dst_port_checker_tb.sv
`timescale 1ns/1ps
module dst_port_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  own_addr_i = 4'h6;
    logic        req_n_i = 1'b1;
    logic        dav_n_i = 1'b1;
    logic [15:0] data_i = '0;
    logic [1:0]  par_i = '0;
    logic        grant_n_o, drcv_n_o, out_valid_o;
    logic [15:0] out_data_o;

    always #10 clk = ~clk;

    dst_port_checker dut_i (
        .clk(clk), .rst_n(rst_n), .own_addr_i(own_addr_i),
        .req_n_i(req_n_i), .dav_n_i(dav_n_i), .data_i(data_i), .par_i(par_i),
        .grant_n_o(grant_n_o), .drcv_n_o(drcv_n_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o)
    );

    int    checks = 0;
    int    errors = 0;
    int    valid_cnt = 0;
    int    cycles = 0;
    string cur_req = "R4";

    // behavioural reference: 0 idle, 1 waiting setup, 2 open, 3 blocked
    int          m_mode = 0;
    logic        m_prev = 1'b1;
    logic [3:0]  m_addr = 4'h6;
    logic        e_grant = 1'b1, e_drcv = 1'b1, e_valid = 1'b0;
    logic [15:0] e_data = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_prev = 1'b1; m_addr = own_addr_i;
            e_grant = 1'b1; e_drcv = 1'b1; e_valid = 1'b0;
        end else begin
            logic fall, pok;
            fall = m_prev && !dav_n_i;
            pok  = (par_i[1] == ^data_i[15:8]) && (par_i[0] == ^data_i[7:0]);
            e_valid = 1'b0;
            if (req_n_i) begin
                m_mode = 0; e_grant = 1'b1; e_drcv = 1'b1;
            end else if (m_mode == 0) begin
                m_mode = 1;
            end else if (m_mode == 1) begin
                if (fall) begin
                    if (pok && data_i[3:0] == m_addr) begin
                        m_mode = 2; e_grant = 1'b0; e_drcv = 1'b0;
                    end else m_mode = 3;
                end
            end else if (m_mode == 2) begin
                if (fall) begin
                    if (pok) begin
                        e_drcv = 1'b0; e_valid = 1'b1; e_data = data_i;
                    end else begin
                        m_mode = 3; e_grant = 1'b1; e_drcv = 1'b1;
                    end
                end else if (dav_n_i) e_drcv = 1'b1;
            end
            m_prev = dav_n_i;
        end
    end

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (out_valid_o === 1'b1) valid_cnt++;
            check_bit(cur_req, "grant_n", grant_n_o, e_grant);
            check_bit(cur_req, "drcv_n", drcv_n_o, e_drcv);
            check_bit(cur_req, "valid", out_valid_o, e_valid);
            if (e_valid) begin
                checks++;
                if (out_data_o !== e_data) begin
                    errors++;
                    $display("FAIL %s data actual=%h expected=%h", cur_req, out_data_o, e_data);
                end
            end
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_word(input logic [15:0] w, input logic [1:0] p, input int hold);
        data_i = w; par_i = p; dav_n_i = 1'b0;
        tick(hold);
        dav_n_i = 1'b1;
        tick(2);
    endtask

    task automatic start_req();
        req_n_i = 1'b0;
        tick(2);
    endtask

    task automatic stop_req();
        req_n_i = 1'b1;
        tick(2);
    endtask

    initial begin
        int v0;
        tick(3);
        cur_req = "R4";
        check_bit("R4", "reset grant_n", grant_n_o, 1'b1);
        check_bit("R4", "reset drcv_n", drcv_n_o, 1'b1);
        check_bit("R4", "reset valid", out_valid_o, 1'b0);
        rst_n = 1'b1;
        tick(1);
        own_addr_i = 4'h3;   // R10: must not take effect
        tick(2);

        // good setup then two data words
        cur_req = "R5";
        start_req();
        v0 = valid_cnt;
        data_i = 16'h0006; par_i = 2'b00; dav_n_i = 1'b0;
        tick(2);
        check_bit("R5", "grant_n after setup", grant_n_o, 1'b0);
        check_bit("R5", "drcv_n after setup", drcv_n_o, 1'b0);
        dav_n_i = 1'b1;
        tick(2);
        check_bit("R7", "drcv_n released", drcv_n_o, 1'b1);
        check_int("R11", "setup not forwarded", valid_cnt - v0, 0);
        cur_req = "R6";
        put_word(16'hFFF9, 2'b00, 2);
        put_word(16'hFEF8, 2'b11, 3);
        check_int("R6", "data words delivered", valid_cnt - v0, 2);
        check_bit("R7", "drcv_n after second word", drcv_n_o, 1'b1);

        // held-low data-available
        cur_req = "R3";
        v0 = valid_cnt;
        put_word(16'h0F0F, 2'b00, 8);
        check_int("R3", "one word for held line", valid_cnt - v0, 1);

        // bad parity data word, then good word ignored
        cur_req = "R8";
        v0 = valid_cnt;
        put_word(16'h1234, 2'b00, 2);
        check_bit("R8", "grant_n after parity error", grant_n_o, 1'b1);
        put_word(16'h1234, 2'b01, 2);
        check_int("R8", "words after error", valid_cnt - v0, 0);
        check_bit("R8", "drcv_n stays high", drcv_n_o, 1'b1);

        // drop request
        cur_req = "R9";
        stop_req();
        check_bit("R9", "idle grant_n", grant_n_o, 1'b1);

        // address changed after reset is ignored
        cur_req = "R10";
        start_req();
        put_word(16'h0003, 2'b00, 2);
        check_bit("R10", "new input address rejected", grant_n_o, 1'b1);
        stop_req();

        // wrong address
        cur_req = "R2";
        start_req();
        put_word(16'h0005, 2'b00, 2);
        check_bit("R2", "misrouted grant_n", grant_n_o, 1'b1);
        put_word(16'h0006, 2'b00, 2);
        check_bit("R2", "later setup ignored", grant_n_o, 1'b1);
        stop_req();

        // bad parity setup, then seven-ones byte setup
        cur_req = "R1";
        start_req();
        put_word(16'h0006, 2'b01, 2);
        check_bit("R1", "bad parity setup", grant_n_o, 1'b1);
        stop_req();
        start_req();
        put_word(16'h7F06, 2'b10, 2);
        check_bit("R1", "seven ones setup", grant_n_o, 1'b0);
        stop_req();

        // edge in the first request cycle is not taken
        cur_req = "R9";
        req_n_i = 1'b0; data_i = 16'h0006; par_i = 2'b00; dav_n_i = 1'b0;
        tick(2);
        dav_n_i = 1'b1;
        tick(2);
        check_bit("R9", "arming cycle edge ignored", grant_n_o, 1'b1);
        put_word(16'h0006, 2'b00, 2);
        check_bit("R9", "setup after arming", grant_n_o, 1'b0);
        stop_req();

        tick(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule